// File: doc/BRIEF.md
# Pipeline Interlock Stall Controller

This block is the hazard interlock of a five-stage in-order pipeline. Each cycle it looks at the source register numbers that the instruction in the decode stage really uses. It compares them with the destination registers of the two older instructions in the execute and memory stages. When an operand cannot reach the consumer in time, it raises a hold. The hold stops the program counter and the fetch/decode latch, and a bubble enters the execute stage in place of the held instruction.

The block keeps its own small record of what sits in execute and memory: the destination number and a load flag. It fills that record from the decode-stage fields that it is given, so the only inputs it needs are those fields. A parameter selects one of two builds. With full forwarding, a stall happens only when the consumer needs the result of a load that is still in execute. Without forwarding, the consumer waits in decode until its producer reaches write-back, because the register file writes before it is read in the same cycle. The datapath, the forwarding multiplexers and the register file belong to other blocks.

Top module: `stall_interlock`

## Requirements
- R1: After reset, hold_o is 0, fetch_en_o is 1, and the execute and memory records read as empty (ex_dst_o = 0, ex_load_o = 0, me_dst_o = 0).
- R2: A source register number of 0 never matches anything, so it never causes a hold.
- R3: A recorded destination of 0 means the instruction writes no register, and it never causes a hold.
- R4: A source field whose use flag (id_rs_used_i or id_rt_used_i) is 0 is ignored, whatever its value.
- R5: With full forwarding, hold_o is 1 exactly when a used, nonzero source equals the execute-stage destination and that instruction is a load.
- R6: With full forwarding, no hold is caused by a non-load producer in execute, or by any producer in memory.
- R7: Without forwarding, hold_o is 1 exactly when a used, nonzero source equals the execute-stage destination or the memory-stage destination.
- R8: A producer that has reached write-back never causes a hold, whichever build is chosen.
- R9: While hold_o is 1, fetch_en_o is 0. On the next cycle, the execute record is a bubble (destination 0, not a load).
- R10: When the decode instruction is valid and not held, its destination and load flag appear at ex_dst_o and ex_load_o one cycle later. An invalid decode slot enters execute as a bubble.
- R11: The execute destination moves to me_dst_o on every cycle, whether hold_o is 0 or 1.
- R12: A consumer placed right after a producer on which it depends is held for 1 cycle behind a load when forwarding is present. Without forwarding, it is held for 2 cycles behind any producer.
- R13: When id_valid_i is 0, hold_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_rs_i | input | REG_BITS | First source register number |
| id_rs_used_i | input | 1 | First source is read by this instruction |
| id_rt_i | input | REG_BITS | Second source register number |
| id_rt_used_i | input | 1 | Second source is read by this instruction |
| id_dst_i | input | REG_BITS | Destination register of the decode instruction, 0 for none |
| id_load_i | input | 1 | Decode instruction is a load |
| hold_o | output | 1 | Stall: freeze the front end and inject a bubble |
| fetch_en_o | output | 1 | Clock enable for the PC and the fetch/decode latch |
| ex_dst_o | output | REG_BITS | Destination recorded for the execute stage |
| ex_load_o | output | 1 | Execute-stage instruction is a load |
| me_dst_o | output | REG_BITS | Destination recorded for the memory stage |

## Verification
The hardest case to reach is a consumer that meets its producer in the memory stage, or in write-back, right after a stall has already put a bubble into execute. Here the outcome depends on how the earlier hold changed the record. Random stimulus reaches this case by drawing register numbers from only four values, so matches are frequent. Short directed sequences then place a load or an ALU producer followed by its consumer, a consumer two slots later, and consumers whose matching field is unused or is register zero. The bench counts the hold cycles of each build and compares them with fixed expected counts.

// File: rtl/stall_pkg.sv
package stall_pkg;

    localparam int unsigned NUM_SRC = 2;

    typedef enum logic {
        FWD_NONE = 1'b0,
        FWD_FULL = 1'b1
    } fwd_mode_e;

endpackage

// File: rtl/src_match.sv
module src_match #(
    parameter int unsigned REG_BITS = 5
) (
    input  logic [REG_BITS-1:0] src_i,
    input  logic                used_i,
    input  logic [REG_BITS-1:0] ex_dst_i,
    input  logic                ex_block_i,
    input  logic [REG_BITS-1:0] me_dst_i,
    input  logic                me_block_i,
    output logic                conflict_o
);

    logic live;
    logic hit_ex;
    logic hit_me;

    always_comb begin
        // register zero is never a real dependence
        live       = used_i && (src_i != '0);
        hit_ex     = (src_i == ex_dst_i) && ex_block_i;
        hit_me     = (src_i == me_dst_i) && me_block_i;
        conflict_o = live && (hit_ex || hit_me);
    end

endmodule

// File: rtl/stage_track.sv
module stage_track #(
    parameter int unsigned REG_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_i,
    input  logic                id_valid_i,
    input  logic [REG_BITS-1:0] id_dst_i,
    input  logic                id_load_i,
    output logic [REG_BITS-1:0] ex_dst_o,
    output logic                ex_load_o,
    output logic [REG_BITS-1:0] me_dst_o
);

    typedef struct packed {
        logic [REG_BITS-1:0] ex_dst;
        logic                ex_load;
        logic [REG_BITS-1:0] me_dst;
    } track_t;

    track_t st_d;
    track_t st_q;

    always_comb begin
        st_d        = st_q;
        st_d.me_dst = st_q.ex_dst;
        if (hold_i || !id_valid_i) begin
            st_d.ex_dst  = '0;
            st_d.ex_load = 1'b0;
        end else begin
            st_d.ex_dst  = id_dst_i;
            st_d.ex_load = id_load_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_dst_o  = st_q.ex_dst;
    assign ex_load_o = st_q.ex_load;
    assign me_dst_o  = st_q.me_dst;

    AST_BUBBLE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (ex_dst_o == '0 && !ex_load_o)); // R9

    AST_EX_TO_ME: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (me_dst_o == $past(ex_dst_o))); // R11

    AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && id_valid_i) |=> (ex_dst_o == $past(id_dst_i) && ex_load_o == $past(id_load_i))); // R10

endmodule

// File: rtl/stall_interlock.sv
module stall_interlock #(
    parameter int unsigned           REG_BITS = 5,
    parameter stall_pkg::fwd_mode_e  FWD_MODE = stall_pkg::FWD_FULL
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                id_valid_i,
    input  logic [REG_BITS-1:0] id_rs_i,
    input  logic                id_rs_used_i,
    input  logic [REG_BITS-1:0] id_rt_i,
    input  logic                id_rt_used_i,
    input  logic [REG_BITS-1:0] id_dst_i,
    input  logic                id_load_i,
    output logic                hold_o,
    output logic                fetch_en_o,
    output logic [REG_BITS-1:0] ex_dst_o,
    output logic                ex_load_o,
    output logic [REG_BITS-1:0] me_dst_o
);

    import stall_pkg::*;

    logic [REG_BITS-1:0] src_num  [NUM_SRC];
    logic                src_used [NUM_SRC];
    logic [NUM_SRC-1:0]  conflict;
    logic                ex_block;
    logic                me_block;
    logic                hold;

    assign src_num[0]  = id_rs_i;
    assign src_used[0] = id_rs_used_i;
    assign src_num[1]  = id_rt_i;
    assign src_used[1] = id_rt_used_i;

    generate
        if (FWD_MODE == FWD_FULL) begin : g_fwd
            // forwarding covers everything except a load still in execute
            assign ex_block = ex_load_o;
            assign me_block = 1'b0;

            AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                hold_o |-> ex_load_o); // R5

            AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
                hold_o |=> !hold_o); // R12
        end else begin : g_nofwd
            // wait until the producer reaches write-back
            assign ex_block = 1'b1;
            assign me_block = 1'b1;

            AST_NB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                hold_o |-> (ex_dst_o != '0 || me_dst_o != '0)); // R7
        end
    endgenerate

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            src_match #(
                .REG_BITS (REG_BITS)
            ) i_src_match (
                .src_i      (src_num[s]),
                .used_i     (src_used[s]),
                .ex_dst_i   (ex_dst_o),
                .ex_block_i (ex_block),
                .me_dst_i   (me_dst_o),
                .me_block_i (me_block),
                .conflict_o (conflict[s])
            );
        end
    endgenerate

    assign hold       = id_valid_i && (|conflict);
    assign hold_o     = hold;
    assign fetch_en_o = !hold;

    stage_track #(
        .REG_BITS (REG_BITS)
    ) i_stage_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .id_valid_i (id_valid_i),
        .id_dst_i   (id_dst_i),
        .id_load_i  (id_load_i),
        .ex_dst_o   (ex_dst_o),
        .ex_load_o  (ex_load_o),
        .me_dst_o   (me_dst_o)
    );

    AST_ZERO_SRCS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs_i == '0 && id_rt_i == '0) |-> !hold_o); // R2

    AST_UNUSED_SRCS: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_rs_used_i && !id_rt_used_i) |-> !hold_o); // R4

    AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid_i |-> !hold_o); // R13

endmodule

// File: tb/test_stall_interlock.sv
module test_stall_interlock;

    import stall_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RB         = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          v = 1'b0;
    logic [RB-1:0] rs = '0;
    logic          rs_u = 1'b0;
    logic [RB-1:0] rt = '0;
    logic          rt_u = 1'b0;
    logic [RB-1:0] dst = '0;
    logic          ld = 1'b0;

    logic          hold [2];
    logic          fen  [2];
    logic [RB-1:0] exd  [2];
    logic          exl  [2];
    logic [RB-1:0] med  [2];

    logic [RB-1:0] rex  [2];
    logic          rexl [2];
    logic [RB-1:0] rme  [2];
    logic          lasth[2];
    int            hcnt [2];

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stall_interlock #(.REG_BITS(RB), .FWD_MODE(FWD_FULL)) i_stall_interlock (
        .clk(clk), .rst_n(rst_n), .id_valid_i(v), .id_rs_i(rs), .id_rs_used_i(rs_u),
        .id_rt_i(rt), .id_rt_used_i(rt_u), .id_dst_i(dst), .id_load_i(ld),
        .hold_o(hold[0]), .fetch_en_o(fen[0]), .ex_dst_o(exd[0]), .ex_load_o(exl[0]),
        .me_dst_o(med[0]));

    stall_interlock #(.REG_BITS(RB), .FWD_MODE(FWD_NONE)) i_stall_interlock_nb (
        .clk(clk), .rst_n(rst_n), .id_valid_i(v), .id_rs_i(rs), .id_rs_used_i(rs_u),
        .id_rt_i(rt), .id_rt_used_i(rt_u), .id_dst_i(dst), .id_load_i(ld),
        .hold_o(hold[1]), .fetch_en_o(fen[1]), .ex_dst_o(exd[1]), .ex_load_o(exl[1]),
        .me_dst_o(med[1]));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // m=0: full forwarding, m=1: no forwarding
    function automatic logic src_hit(input int m, input logic [RB-1:0] s, input logic u);
        if (!u || s == '0) return 1'b0;
        if (m == 0) return (s == rex[m]) && rexl[m];
        return (s == rex[m]) || (s == rme[m]);
    endfunction

    function automatic logic exp_hold(input int m);
        return v && (src_hit(m, rs, rs_u) || src_hit(m, rt, rt_u));
    endfunction

    task automatic drive(input logic nv, input logic [RB-1:0] a, input logic ua,
                         input logic [RB-1:0] b, input logic ub,
                         input logic [RB-1:0] d, input logic nl);
        logic eh [2];
        for (int m = 0; m < 2; m++) begin
            check(lasth[m] ? "R9 ex bubble dst" : "R10 ex dst", exd[m], rex[m]);
            check(lasth[m] ? "R9 ex bubble load" : "R10 ex load", exl[m], rexl[m]);
            check("R11 me dst", med[m], rme[m]);
        end
        v = nv; rs = a; rs_u = ua; rt = b; rt_u = ub; dst = d; ld = nl;
        #1;
        for (int m = 0; m < 2; m++) begin
            eh[m] = exp_hold(m);
            check(!v ? "R13 hold" : (m == 0 ? "R5 hold" : "R7 hold"), hold[m], eh[m]);
            check("R9 fetch enable", fen[m], !eh[m]);
            hcnt[m] += int'(hold[m]);
        end
        @(posedge clk);
        for (int m = 0; m < 2; m++) begin
            rme[m] = rex[m];
            if (eh[m] || !v) begin
                rex[m] = '0; rexl[m] = 1'b0;
            end else begin
                rex[m] = d; rexl[m] = nl;
            end
            lasth[m] = eh[m];
        end
        @(negedge clk);
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
        hcnt[0] = 0; hcnt[1] = 0;
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            rex[m] = '0; rexl[m] = 1'b0; rme[m] = '0; lasth[m] = 1'b0; hcnt[m] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int m = 0; m < 2; m++) begin
            check("R1 reset hold", hold[m], 0);
            check("R1 reset fetch", fen[m], 1);
            check("R1 reset ex", exd[m], 0);
            check("R1 reset exl", exl[m], 0);
            check("R1 reset me", med[m], 0);
        end
        @(negedge clk);

        // R12: load r1, then consumer of r1 (no destination)
        flush();
        drive(1'b1, 5'd2, 1'b1, 5'd0, 1'b0, 5'd1, 1'b1);
        for (int i = 0; i < 4; i++) drive(1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
        check("R12 load-use holds fwd", hcnt[0], 1);
        check("R12 load-use holds nofwd", hcnt[1], 2);

        // R6: ALU producer r2, consumer uses r2 in second field
        flush();
        drive(1'b1, 5'd3, 1'b1, 5'd0, 1'b0, 5'd2, 1'b0);
        for (int i = 0; i < 4; i++) drive(1'b1, 5'd0, 1'b0, 5'd2, 1'b1, 5'd0, 1'b0);
        check("R6 alu producer fwd", hcnt[0], 0);
        check("R12 alu producer nofwd", hcnt[1], 2);

        // R2 / R3: producer writes nothing, consumer reads register zero
        flush();
        drive(1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b1);
        drive(1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0);
        drive(1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0);
        check("R2 R3 zero fwd", hcnt[0], 0);
        check("R2 R3 zero nofwd", hcnt[1], 0);

        // R4: load r1, consumer has r1 only in an unused field
        flush();
        drive(1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd1, 1'b1);
        drive(1'b1, 5'd1, 1'b0, 5'd1, 1'b0, 5'd4, 1'b0);
        drive(1'b1, 5'd1, 1'b0, 5'd1, 1'b0, 5'd4, 1'b0);
        check("R4 unused field fwd", hcnt[0], 0);
        check("R4 unused field nofwd", hcnt[1], 0);

        // R8: producer r3 reaches write-back when consumer is decoded
        flush();
        drive(1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd3, 1'b1);
        drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
        drive(1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
        drive(1'b1, 5'd3, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0);
        check("R8 writeback fwd", hcnt[0], 0);
        check("R8 writeback nofwd", hcnt[1], 0);

        // R13: invalid slot behind a load with matching sources
        flush();
        drive(1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, 1'b1);
        drive(1'b0, 5'd2, 1'b1, 5'd2, 1'b1, 5'd0, 1'b0);
        check("R13 invalid fwd", hcnt[0], 0);
        check("R13 invalid nofwd", hcnt[1], 0);

        // random mix
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 8) != 0,
                  RB'($urandom % 4), 1'($urandom), RB'($urandom % 4), 1'($urandom),
                  RB'($urandom % 4), ($urandom % 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule